// File: doc/BRIEF.md
# Sequential Integer Square Root

This unit takes a 64-bit unsigned operand and produces the 32-bit floor of its square root. It works through the root from the top bit down. For each position it sets the bit in a running candidate and squares that candidate. If the square is larger than the operand, it clears the bit again. A small multiplier squares the candidate over several cycles, handling a group of multiplier bits per cycle. This keeps the datapath to one adder tree a few partial products wide, with no full-width array.

The operand is loaded by holding `rst` high. The same action aborts any computation in progress. Work starts on the first clock edge after `rst` falls. `done` rises when the root is final, and the root then stays put until the next reset. While the unit is working, `root` shows the partial candidate.

Top module: `isqrt_seq`

## Requirements
- R1: When `done` is high and `rst` is low, `root` equals floor(sqrt(operand)): `root*root <= operand < (root+1)*(root+1)`.
- R2: The operand is sampled on every clock edge while `rst` is high. Changes on `operand` after `rst` falls have no effect on the result.
- R3: Reset is synchronous and active high. On the edge after `rst` is seen high, `done` is 0 and `root` is 0.
- R4: Raising `rst` during a computation discards the partial result. The operand presented during that reset is computed from scratch after release.
- R5: `done` first reads high exactly RES_W*(RES_W/DIGIT+2) clock edges after the edge at which `rst` was last sampled high. With the defaults (RES_W=32, DIGIT=2), this is 576 edges.
- R6: Once `done` is high, `done` stays high and `root` stays unchanged until `rst` is asserted again.
- R7: Operand 0 gives 0, operand 0xFFFF_FFFF_FFFF_FFFF gives 0xFFFF_FFFF, and operand 0x7FFF_FFFF_FFFF_FFFF gives 0xB504_F333.
- R8: While a computation runs, `root` only ever gains bits. Every bit it shows is a bit of the final result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset and operand load, active high |
| operand | input | 64 | Unsigned value whose root is wanted, sampled while `rst` is high |
| root | output | 32 | Partial candidate while working; the floor square root once `done` is high |
| done | output | 1 | High from the moment the root is final until the next reset |

## Verification
A corrupted multiplier accumulator or candidate register shows up as a wrong root when `done` rises. That is about 576 cycles after release, so every operand in the sweep exposes it within one computation. A wrong bit index or phase counter shifts the cycle at which `done` rises, and the exact latency check catches that on the first run. A candidate bit that is set wrongly and later cleared is visible at once on `root`. The bench compares `root` with the final value on every cycle of the computation.

// File: rtl/isqrt_seq.sv
module isqrt_seq #(
  parameter int OP_W  = 64,
  parameter int DIGIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] operand,
  output logic [OP_W/2-1:0] root,
  output logic            done
);
  localparam int RES_W = OP_W / 2;
  localparam int STEPS = RES_W / DIGIT;
  localparam int IDX_W = $clog2(RES_W);
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  typedef enum logic [1:0] {PH_SET, PH_MUL, PH_CMP, PH_FIN} phase_t;

  phase_t           phase;
  logic [OP_W-1:0]  opnd, acc, mcand, pp;
  logic [RES_W-1:0] cand, trial, mplier;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    pp = '0;
    for (int k = 0; k < DIGIT; k++)
      if (mplier[k]) pp = pp + (mcand << k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd  <= operand;
      cand  <= '0;
      trial <= '0;
      idx   <= IDX_W'(RES_W - 1);
      cnt   <= '0;
      acc   <= '0;
      mcand <= '0;
      mplier <= '0;
      phase <= PH_SET;
      done  <= 1'b0;
    end else begin
      case (phase)
        PH_SET: begin
          trial  <= cand | (RES_W'(1) << idx);
          mcand  <= OP_W'(cand | (RES_W'(1) << idx));
          mplier <= cand | (RES_W'(1) << idx);
          acc    <= '0;
          cnt    <= '0;
          phase  <= PH_MUL;
        end
        PH_MUL: begin
          acc    <= acc + pp;
          mcand  <= mcand << DIGIT;
          mplier <= mplier >> DIGIT;
          cnt    <= cnt + 1'b1;
          if (cnt == CNT_W'(STEPS - 1)) phase <= PH_CMP;
        end
        PH_CMP: begin
          if (acc <= opnd) cand <= trial;
          if (idx == '0) begin
            phase <= PH_FIN;
            done  <= 1'b1;
          end else begin
            idx   <= idx - 1'b1;
            phase <= PH_SET;
          end
        end
        default: ;
      endcase
    end
  end

  assign root = cand;

  logic [OP_W+1:0] sq_lo, sq_hi, opnd_x;
  assign sq_lo  = (OP_W+2)'(root) * (OP_W+2)'(root);
  assign sq_hi  = ((OP_W+2)'(root) + 1'b1) * ((OP_W+2)'(root) + 1'b1);
  assign opnd_x = (OP_W+2)'(opnd);

  a_r1_floor: assert property (@(posedge clk) disable iff (rst)
    done |-> (sq_lo <= opnd_x) && (sq_hi > opnd_x));

  a_r3_reset_clears: assert property (@(posedge clk)
    rst |=> (!done && root == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(root)));

  a_r8_grow: assert property (@(posedge clk) disable iff (rst)
    !done |=> ((root & $past(root)) == $past(root)));

  a_r2_opnd_kept: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(opnd));
endmodule

// File: tb/isqrt_seq_test.sv
`timescale 1ns / 1ps
module isqrt_seq_test;
  localparam int LAT = 32 * (16 + 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] operand = '0;
  logic [31:0] root;
  logic        done;
  int checks = 0, fails = 0;
  bit timed_out = 1'b0;

  isqrt_seq uut (.clk(clk), .rst(rst), .operand(operand), .root(root), .done(done));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] ref_root(input logic [63:0] v);
    logic [31:0] c = '0;
    for (int i = 31; i >= 0; i--) begin
      c[i] = 1'b1;
      if (64'(c) * 64'(c) > v) c[i] = 1'b0;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] v, input bit scramble, input bit hold);
    logic [31:0] exp = ref_root(v);
    int n = 0;
    bit grew_ok = 1'b1;
    @(negedge clk); rst = 1'b1; operand = v;
    @(negedge clk);
    chk("R3 done", 64'(done), 64'd0);
    chk("R3 root", 64'(root), 64'd0);
    rst = 1'b0;
    if (scramble) operand = ~v;
    while (!done && n < LAT + 10) begin
      @(negedge clk); n++;
      if ((root & ~exp) != 0) grew_ok = 1'b0;
    end
    chk("R5 latency", 64'(n), 64'(LAT));
    chk("R8 partial bits", 64'(grew_ok), 64'd1);
    chk(scramble ? "R2 R1 root" : "R1 root", 64'(root), 64'(exp));
    if (hold) begin
      operand = 64'h1234;
      repeat (7) @(negedge clk);
      chk("R6 done held", 64'(done), 64'd1);
      chk("R6 root held", 64'(root), 64'(exp));
    end
  endtask

  initial begin
    #(5.0 * 200000);
    timed_out = 1'b1;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] sweep;
    repeat (3) @(negedge clk);
    chk("R3 reset done", 64'(done), 64'd0);
    run(64'd0, 0, 1);
    chk("R7 zero", 64'(root), 64'd0);
    run(64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    chk("R7 all ones", 64'(root), 64'hFFFF_FFFF);
    run(64'h7FFF_FFFF_FFFF_FFFF, 1, 0);
    chk("R7 half range", 64'(root), 64'hB504_F333);
    run(64'd4, 0, 0);
    run(64'd121, 1, 0);
    run(64'd1000000, 0, 1);
    run(64'd130, 1, 0);
    // R4: abort a running computation, then load a new operand
    @(negedge clk); rst = 1'b1; operand = 64'hFFFF_0000_FFFF_0000;
    @(negedge clk); rst = 1'b0;
    repeat (200) @(negedge clk);
    run(64'd3, 0, 0);
    chk("R4 abort result", 64'(root), 64'd1);
    sweep = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int j = 0; j < 30; j++) begin
      run(sweep, j[0], 0);
      sweep = sweep - 64'h0000_0000_7FFF_FFFF;
    end
    for (int j = 0; j < 40; j++) run({$urandom, $urandom}, j[0], 0);
    for (int j = 1; j < 6; j++) begin
      run(64'(j * j) - 1, 0, 0);
      run(64'(j * j), 0, 0);
    end
    if (!timed_out) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule